// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through data cache and a slower memory port. Every store that the processor writes into the cache is also pushed into a small first-in first-out queue. A drain engine then presents the queued writes to memory in arrival order, one per accepted handshake. A dirty line that the cache evicts on a read miss is pushed into the same queue. The demand read therefore goes out first, and the eviction write follows later with the other queued writes.

A read-miss request does not wait behind the queue. Its line address is compared in parallel against every valid queued entry. If no entry holds the same line, the read takes the memory port at once, ahead of all pending writes. If an entry matches, the read is held back. Writes keep draining until no queued entry holds that line, and only then is the read issued, so it returns current data. When stores arrive faster than memory retires them, the queue fills and the producer is stalled.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `st_ready` and `vic_ready` are 1, and with no read request `mem_valid` is 0.
- R2: Queued writes are presented on the memory port with `mem_we`=1, carrying their own address and data, strictly in the order they were pushed. A write leaves the queue only on a cycle where `mem_valid`, `mem_we` and `mem_ready` are all 1.
- R3: `full` is 1 exactly when DEPTH entries are queued. While full, and with no write retiring in the same cycle, `st_ready` and `vic_ready` are 0 and the queue contents stay unchanged.
- R4: When the queue is full and a write retires in a cycle, a push in that same cycle is accepted, and the queue stays full.
- R5: A read request whose line matches no queued entry is presented on the memory port in the same cycle, with `mem_we`=0 and `mem_addr`=`rd_addr`, ahead of any queued write. `rd_ready` then equals `mem_ready`.
- R6: A read request whose line matches any queued entry gets `rd_ready`=0 and is not presented while the match remains. Queued writes drain meanwhile, and the read is issued in the first cycle that no queued entry matches.
- R7: Line comparison uses address bits [ADDR_W-1:OFFS_W] only. Two addresses that differ only in the low OFFS_W bits (OFFS_W=4 by default) count as a match.
- R8: An evicted-line push (`vic_valid`) wins over a store push in the same cycle: `st_ready` is 0 while `vic_valid` is 1. The evicted line enters the queue, so a following read to another line reaches memory before the eviction write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store push request |
| st_ready | output | 1 | Store push accepted this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| vic_valid | input | 1 | Evicted dirty line push request |
| vic_ready | output | 1 | Evicted line accepted this cycle |
| vic_addr | input | ADDR_W | Evicted line address |
| vic_data | input | DATA_W | Evicted line data |
| rd_valid | input | 1 | Read-miss request |
| rd_ready | output | 1 | Read accepted by memory this cycle |
| rd_addr | input | ADDR_W | Read-miss address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write from queue head, 0 = read |
| mem_addr | output | ADDR_W | Memory request address |
| mem_data | output | DATA_W | Write data (queue head) |
| full | output | 1 | All DEPTH entries occupied |

## Verification
Two events can meet in one cycle. The first is a push into a full queue while a write retires, which is the R4 swap. The second is a read request raised while its line is still queued, so that the conflict search and the drain of the matching entry overlap. The bench provokes both on purpose. It fills the queue with memory stalled, offers one more store, then raises `mem_ready` while a read to an offset-shifted address of the head line is pending. The random phase keeps them recurring by drawing addresses from only eight lines. Every cycle, a reference queue in the bench predicts the memory-port choice, the handshake readies and the full flag.

// File: rtl/wbuf_pkg.sv
// Package wbuf_pkg
// Shared types for the write buffer: which requester owns the memory port
// in a given cycle. Assumes nothing beyond synthesizable enums.
package wbuf_pkg;

    typedef enum logic [1:0] {
        GNT_IDLE  = 2'd0,
        GNT_READ  = 2'd1,
        GNT_WRITE = 2'd2
    } mem_gnt_e;

endpackage

// File: rtl/wbuf_fifo.sv
// Module wbuf_fifo
// Circular queue of DEPTH address/data entries with a valid bit per slot.
// Exposes the line tag of every slot for the conflict search, plus the head
// entry for draining. Assumes the caller never pushes when full without a
// same-cycle pop, and never pops when empty.
module wbuf_fifo #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int OFFS_W = 4,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LINE_W = ADDR_W - OFFS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [DATA_W-1:0]             head_data,
    output logic [DEPTH-1:0][LINE_W-1:0]  ent_line,
    output logic [DEPTH-1:0]              ent_vld,
    output logic [CNT_W-1:0]              count,
    output logic                          full,
    output logic                          empty
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q, vld_d;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Next valid vector: a retiring slot clears, a filled slot sets (set wins).
    always_comb begin
        vld_d = vld_q;
        if (pop)  vld_d[rd_ptr] = 1'b0;
        if (push) vld_d[wr_ptr] = 1'b1;
    end

    // Next occupancy count from the push/pop pair.
    always_comb begin
        case ({push, pop})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // Control state: pointers, count and valid bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            vld_q  <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            cnt_q <= cnt_d;
            vld_q <= vld_d;
        end
    end

    // Payload storage: written on push, needs no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Line tags of every slot for the associative search.
    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        assign ent_line[g] = addr_q[g][ADDR_W-1:OFFS_W];
    end

    assign ent_vld   = vld_q;
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign count     = cnt_q;
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);

endmodule

// File: rtl/wbuf_match.sv
// Module wbuf_match
// Parallel line-address comparator over all queued slots. Produces a single
// hit flag when any valid slot holds the requested line. Purely combinational.
module wbuf_match #(
    parameter int LINE_W = 28,
    parameter int DEPTH  = 4
) (
    input  logic [DEPTH-1:0][LINE_W-1:0] ent_line,
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [LINE_W-1:0]            rd_line,
    output logic                         hit
);

    logic [DEPTH-1:0] hit_vec;

    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_line[g] == rd_line);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/wbuf_arb.sv
// Module wbuf_arb
// Memory port arbiter. A non-conflicting read outranks the queue head; a
// conflicting read waits. The queue head is offered whenever the read does
// not own the port. The port is a per-cycle request: the owner may change
// between cycles while mem_ready is low.
module wbuf_arb
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              rd_valid,
    input  logic              rd_hit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_avail,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              rd_ready,
    output logic              pop
);

    mem_gnt_e gnt;

    // Pick this cycle's port owner.
    always_comb begin
        if (rd_valid && !rd_hit) gnt = GNT_READ;
        else if (wr_avail)       gnt = GNT_WRITE;
        else                     gnt = GNT_IDLE;
    end

    // Drive the memory request and the two completion strobes.
    always_comb begin
        mem_valid = (gnt != GNT_IDLE);
        mem_we    = (gnt == GNT_WRITE);
        mem_addr  = (gnt == GNT_READ) ? rd_addr : head_addr;
        mem_data  = head_data;
        rd_ready  = mem_ready && !rd_hit;
        pop       = (gnt == GNT_WRITE) && mem_ready;
    end

endmodule

// File: rtl/wbuf_bypass.sv
// Module wbuf_bypass (top)
// Write buffer for a write-through cache. Stores and evicted dirty lines
// queue up and drain to memory in order. A read miss bypasses the queue
// unless a queued entry holds its line. Assumes requesters hold valid and
// payload until accepted, and that memory returns read data elsewhere.
module wbuf_bypass #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              vic_valid,
    output logic              vic_ready,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [DATA_W-1:0] vic_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              full
);

    localparam int LINE_W = ADDR_W - OFFS_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic                         push, pop, space, empty, rd_hit;
    logic [ADDR_W-1:0]            push_addr, head_addr;
    logic [DATA_W-1:0]            push_data, head_data;
    logic [DEPTH-1:0][LINE_W-1:0] ent_line;
    logic [DEPTH-1:0]             ent_vld;
    logic [CNT_W-1:0]             count;

    // Push side: a slot is free if not full or the head retires this cycle;
    // the evicted line has priority over a store.
    always_comb begin
        space     = !full || pop;
        vic_ready = space;
        st_ready  = space && !vic_valid;
        push      = (vic_valid && vic_ready) || (st_valid && st_ready);
        push_addr = vic_valid ? vic_addr : st_addr;
        push_data = vic_valid ? vic_data : st_data;
    end

    wbuf_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .OFFS_W (OFFS_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (push_addr),
        .push_data (push_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .ent_line  (ent_line),
        .ent_vld   (ent_vld),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    wbuf_match #(
        .LINE_W (LINE_W),
        .DEPTH  (DEPTH)
    ) u_match (
        .ent_line (ent_line),
        .ent_vld  (ent_vld),
        .rd_line  (rd_addr[ADDR_W-1:OFFS_W]),
        .hit      (rd_hit)
    );

    wbuf_arb #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arb (
        .rd_valid  (rd_valid),
        .rd_hit    (rd_hit),
        .rd_addr   (rd_addr),
        .wr_avail  (!empty),
        .head_addr (head_addr),
        .head_data (head_data),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .rd_ready  (rd_ready),
        .pop       (pop)
    );

endmodule

// File: rtl/wbuf_bypass_chk.sv
// Module wbuf_bypass_chk
// Property checker for wbuf_bypass, attached by bind. Watches the ports plus
// the occupancy count and the conflict flag inside the top.
module wbuf_bypass_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              vic_valid,
    input logic              vic_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_hit,
    input logic [CNT_W-1:0]  count
);

    logic fin, fout, at_full;

    // Handshake events seen at the ports.
    always_comb begin
        fin     = (vic_valid && vic_ready) || (st_valid && st_ready);
        fout    = mem_valid && mem_ready && mem_we;
        at_full = (count == CNT_W'(DEPTH));
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) && !rd_valid |-> !mem_valid);                         // R1

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !fout |=> count == $past(count) + CNT_W'(1));                 // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));                                             // R3

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        at_full && !fout |-> !st_ready && !vic_ready);                       // R3

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        at_full && fout && vic_valid |=> count == CNT_W'(DEPTH));            // R4

    AST_RD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_hit |-> mem_valid && !mem_we && (mem_addr == rd_addr)); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_hit |-> !rd_ready && !(mem_valid && !mem_we));        // R6

    AST_VIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid && st_valid |-> !st_ready);                                // R8

endmodule

bind wbuf_bypass wbuf_bypass_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .rd_hit    (rd_hit),
    .count     (count)
);

// File: tb/tb_wbuf_bypass.sv
// Bench for wbuf_bypass: directed corner cases then seeded random traffic,
// all checked each cycle against a reference queue kept in the bench.
module tb_wbuf_bypass;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam int OFFS  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 0, vic_valid = 0, rd_valid = 0, mem_ready = 0;
    logic [AW-1:0] st_addr = '0, vic_addr = '0, rd_addr = '0;
    logic [DW-1:0] st_data = '0, vic_data = '0;
    logic          st_ready, vic_ready, rd_ready, mem_valid, mem_we, full;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference queue
    logic [AW-1:0] q_addr [0:DEPTH];
    logic [DW-1:0] q_data [0:DEPTH];
    int            q_cnt = 0;
    bit            st_fire, vic_fire, rd_fire;

    always #5 clk = ~clk;

    wbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .OFFS_W(OFFS)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_addr(vic_addr), .vic_data(vic_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .full(full)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] rand_addr();
        return (($urandom % 8) << 4) | ($urandom % 16);
    endfunction

    // Predict this cycle's outputs from the reference queue, compare, then
    // apply the handshakes that complete at the coming edge.
    task automatic model_check();
        bit hit, exp_rd, exp_wr, exp_pop, exp_space;
        hit = 0;
        for (int i = 0; i < q_cnt; i++)
            if ((q_addr[i] >> OFFS) == (rd_addr >> OFFS)) hit = 1;
        exp_rd    = rd_valid && !hit;
        exp_wr    = !exp_rd && (q_cnt > 0);
        exp_pop   = exp_wr && mem_ready;
        exp_space = (q_cnt < DEPTH) || exp_pop;

        chk(64'(mem_valid), 64'(exp_rd || exp_wr), exp_rd ? "R5" : "R2");
        if (exp_rd) begin
            chk(64'(mem_we), 64'(0), "R5");
            chk(64'(mem_addr), 64'(rd_addr), "R5");
        end else if (exp_wr) begin
            chk(64'(mem_we), 64'(1), rd_valid ? "R6" : "R2");
            chk(64'(mem_addr), 64'(q_addr[0]), "R2");
            chk(64'(mem_data), 64'(q_data[0]), "R2");
        end
        if (rd_valid) chk(64'(rd_ready), 64'(mem_ready && !hit), hit ? "R6" : "R5");
        chk(64'(full), 64'(q_cnt == DEPTH), "R3");
        chk(64'(vic_ready), 64'(exp_space), (q_cnt == DEPTH && exp_pop) ? "R4" : "R3");
        chk(64'(st_ready), 64'(exp_space && !vic_valid), vic_valid ? "R8" : "R3");

        rd_fire  = exp_rd && mem_ready;
        vic_fire = vic_valid && exp_space;
        st_fire  = st_valid && exp_space && !vic_valid;
        if (exp_pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                q_addr[i] = q_addr[i+1];
                q_data[i] = q_data[i+1];
            end
            q_cnt--;
        end
        if (vic_fire) begin
            q_addr[q_cnt] = vic_addr; q_data[q_cnt] = vic_data; q_cnt++;
        end else if (st_fire) begin
            q_addr[q_cnt] = st_addr; q_data[q_cnt] = st_data; q_cnt++;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        model_check();
        @(posedge clk);
        #1;
    endtask

    task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_valid = 1; st_addr = a; st_data = d;
        do cyc(); while (!st_fire);
        st_valid = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        @(negedge clk);
        chk(64'(full), 64'(0), "R1");
        chk(64'(st_ready), 64'(1), "R1");
        chk(64'(vic_ready), 64'(1), "R1");
        chk(64'(mem_valid), 64'(0), "R1");
        @(posedge clk); #1;

        // R3: fill with memory stalled, then offer a fifth store
        mem_ready = 0;
        push_store(32'h0000_0100, 32'hA0);
        push_store(32'h0000_0200, 32'hB1);
        push_store(32'h0000_0300, 32'hC2);
        push_store(32'h0000_0400, 32'hD3);
        st_valid = 1; st_addr = 32'h0000_0500; st_data = 32'hE4;
        repeat (2) begin
            @(negedge clk);
            chk(64'(full), 64'(1), "R3");
            chk(64'(st_ready), 64'(0), "R3");
            model_check();
            @(posedge clk); #1;
        end

        // R7: read to the head line at a different offset is held
        rd_valid = 1; rd_addr = 32'h0000_0108;
        @(negedge clk);
        chk(64'(rd_ready), 64'(0), "R7");
        chk(64'(mem_we), 64'(1), "R7");
        model_check();
        @(posedge clk); #1;

        // R4: head retires while full and the pending store enters
        mem_ready = 1;
        @(negedge clk);
        chk(64'(st_ready), 64'(1), "R4");
        model_check();
        @(posedge clk); #1;
        st_valid = 0;

        // R5/R6: matching line gone, read now bypasses queued writes
        @(negedge clk);
        chk(64'(mem_we), 64'(0), "R6");
        chk(64'(mem_addr), 64'(32'h0000_0108), "R5");
        model_check();
        @(posedge clk); #1;
        rd_valid = 0;
        repeat (8) cyc();

        // R8: eviction and store together, then a read overtakes the eviction
        mem_ready = 0;
        vic_valid = 1; vic_addr = 32'h0000_0700; vic_data = 32'h77;
        st_valid = 1; st_addr = 32'h0000_0800; st_data = 32'h88;
        @(negedge clk);
        chk(64'(st_ready), 64'(0), "R8");
        chk(64'(vic_ready), 64'(1), "R8");
        model_check();
        @(posedge clk); #1;
        vic_valid = 0;
        do cyc(); while (!st_fire);
        st_valid = 0;
        rd_valid = 1; rd_addr = 32'h0000_0900; mem_ready = 1;
        @(negedge clk);
        chk(64'(mem_we), 64'(0), "R8");
        model_check();
        @(posedge clk); #1;
        rd_valid = 0;
        repeat (6) cyc();

        // Random phase: small line pool to provoke conflicts and saturation
        for (int n = 0; n < 4000; n++) begin
            mem_ready = ($urandom % 2) == 0;
            cyc();
            if (!st_valid || st_fire) begin
                st_valid = ($urandom % 3) == 0;
                st_addr = rand_addr(); st_data = $urandom;
            end
            if (!vic_valid || vic_fire) begin
                vic_valid = ($urandom % 9) == 0;
                vic_addr = rand_addr(); vic_data = $urandom;
            end
            if (!rd_valid || rd_fire) begin
                rd_valid = ($urandom % 4) == 0;
                rd_addr = rand_addr();
            end
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R2: watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule